// File: doc/BRIEF.md
# Per-Master Flash Access Guard

This block sits between two bus slave ports and a flash array. It screens every request before the array sees it. Each port presents a master identifier, a direction bit, an instruction/data attribute and an address in its address phase. The guard then either forwards the request to the array in that same cycle, or withholds it and answers the master with the two-beat error response used on AHB.

Two rules decide whether a request is refused. The first is a per-master permission field, which sets read and write rights separately. The second is an execute-lock on a fixed boot-assist address window. When the lock is enabled, any instruction fetch that lands in the window is refused, whatever the master's permission says. Data reads and data writes to the same window are still governed only by the permission field. Both ports are checked at the same time, each with its own error sequencer.

A saturating violation counter and a sticky record of the first offending master are kept for observation. The configuration is supplied as static input vectors.

Top module: `flash_access_guard`

## Requirements
- R1: While reset is held, and on leaving it, every port shows `p_hready`=1, `p_hresp`=0 and `a_req`=0, with `viol_count`=0 and `viol_flag`=0.
- R2: The 2-bit permission field of master m is `cfg_perm[2m+1:2m]`. Bit 0 grants reads and bit 1 grants writes, so 00 means no access, 01 read only, 10 write only and 11 both. A permitted request raises `a_req` in its own cycle, carrying the port's address and direction unchanged.
- R3: A refused request never raises `a_req`. The edge after it is followed by one cycle of `p_hready`=0 with `p_hresp`=1, then one cycle of `p_hready`=1 with `p_hresp`=1, and then the port returns to `p_hready`=1 with `p_hresp`=0.
- R4: The boot window covers addresses from BOOT_BASE up to BOOT_BASE+BOOT_SIZE-1 inclusive. With `cfg_boot_xdis`=1, a request with `p_instr`=1 inside the window is refused even when the permission field allows it.
- R5: Data requests (`p_instr`=0) inside the window, and all requests while `cfg_boot_xdis`=0, are decided by the permission field alone. Addresses just outside either end of the window are not affected by the lock.
- R6: The two ports are judged independently in the same cycle. An error sequence on one port leaves the other port's `p_hready` and `p_hresp` at 1 and 0.
- R7: A request presented during either error cycle of its port is neither forwarded nor counted. If it is still held when the port returns to idle, it is judged then.
- R8: `viol_count` rises after each clock edge by the number of ports that had a refused request in the cycle before. It saturates at 2^CNT_W-1.
- R9: `viol_flag` sets on the first refused request and `viol_mid` captures that request's master ID. Port 0 wins if both ports are refused in the same cycle. Both values then hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_perm | input | 2*NUM_MASTERS | Per-master permission fields |
| cfg_boot_xdis | input | 1 | Execute-lock on the boot window |
| p_req | input | NUM_PORTS | Address-phase request valid, one per port |
| p_mid | input | NUM_PORTS*MID_W | Master ID per port |
| p_write | input | NUM_PORTS | 1 = write, 0 = read |
| p_instr | input | NUM_PORTS | 1 = instruction fetch, 0 = data |
| p_addr | input | NUM_PORTS*ADDR_W | Request address per port |
| p_hready | output | NUM_PORTS | Guard's ready contribution per port |
| p_hresp | output | NUM_PORTS | Error response per port |
| a_req | output | NUM_PORTS | Request forwarded to the array |
| a_write | output | NUM_PORTS | Forwarded direction |
| a_addr | output | NUM_PORTS*ADDR_W | Forwarded address |
| viol_count | output | CNT_W | Saturating count of refused requests |
| viol_flag | output | 1 | Sticky: a request has been refused |
| viol_mid | output | MID_W | Master ID of the first refused request |

## Verification
The hardest conditions to reach from the ports are those that depend on timing between events. One is a request that arrives while its port is still inside an error sequence. Another is both ports being refused on the same edge, which tests counter addition and the port-0 priority of the sticky record. The stimulus creates these on purpose. It holds a request high across both error beats, and it drives both ports against an all-zero permission map in the same cycle. Everything else comes from a full sweep of master, direction, attribute, lock setting and the four addresses around the window edges, under four rotated permission maps. The sweep refuses enough requests to drive the small bench counter into saturation.

// File: rtl/fg_pkg.sv
package fg_pkg;

  typedef enum logic [1:0] {
    FG_IDLE     = 2'd0,
    FG_ERR_WAIT = 2'd1,
    FG_ERR_DONE = 2'd2
  } fg_state_e;

  // field bit 0 grants read, bit 1 grants write
  function automatic logic fg_perm_denies(input logic [1:0] field, input logic is_wr);
    return is_wr ? ~field[1] : ~field[0];
  endfunction

endpackage

// File: rtl/fg_rst_sync.sv
module fg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fg_perm_check.sv
module fg_perm_check
  import fg_pkg::*;
#(
  parameter int NUM_MASTERS = 8,
  parameter int MID_W       = 3,
  parameter int ADDR_W      = 16,
  parameter int BOOT_BASE   = 'h4000,
  parameter int BOOT_SIZE   = 'h0800
) (
  input  logic [2*NUM_MASTERS-1:0] cfg_perm,
  input  logic                     cfg_boot_xdis,
  input  logic [MID_W-1:0]         mid,
  input  logic                     is_wr,
  input  logic                     is_instr,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     deny
);
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(BOOT_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(BOOT_BASE + BOOT_SIZE);

  logic [1:0] field;
  logic       in_window;
  logic       deny_perm;
  logic       deny_boot;

  always_comb begin
    field = 2'b00;  // unknown master IDs get no access
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (mid == MID_W'(m)) field = cfg_perm[2*m +: 2];
    end
  end

  always_comb begin
    in_window = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
    deny_perm = fg_perm_denies(field, is_wr);
    deny_boot = cfg_boot_xdis && is_instr && in_window;
    deny      = deny_perm || deny_boot;
  end
endmodule

// File: rtl/fg_err_fsm.sv
module fg_err_fsm
  import fg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic deny,
  output logic fwd,
  output logic err_evt,
  output logic hready,
  output logic hresp
);
  fg_state_e state_q, state_d;
  logic      idle;

  always_comb begin
    idle    = (state_q == FG_IDLE);
    fwd     = req && idle && !deny;
    err_evt = req && idle && deny;
    hready  = (state_q != FG_ERR_WAIT);
    hresp   = !idle;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      FG_IDLE:     if (err_evt) state_d = FG_ERR_WAIT;
      FG_ERR_WAIT: state_d = FG_ERR_DONE;
      FG_ERR_DONE: state_d = FG_IDLE;
      default:     state_d = FG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FG_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/fg_viol_log.sv
module fg_viol_log #(
  parameter int NUM_PORTS = 2,
  parameter int MID_W     = 3,
  parameter int CNT_W     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS-1:0]       err_evt,
  input  logic [NUM_PORTS*MID_W-1:0] mid_flat,
  output logic [CNT_W-1:0]           viol_count,
  output logic                       viol_flag,
  output logic [MID_W-1:0]           viol_mid
);
  localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_sum;
  logic             cnt_en;
  logic             flag_q, flag_en;
  logic [MID_W-1:0] mid_q, mid_pick;

  always_comb begin
    cnt_sum = {1'b0, cnt_q};
    for (int i = 0; i < NUM_PORTS; i++) cnt_sum = cnt_sum + (CNT_W+1)'(err_evt[i]);
    cnt_en = |err_evt;
    cnt_d  = (cnt_sum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : cnt_sum[CNT_W-1:0];
  end

  always_comb begin
    mid_pick = '0;
    for (int i = NUM_PORTS-1; i >= 0; i--) begin
      if (err_evt[i]) mid_pick = mid_flat[i*MID_W +: MID_W];
    end
    flag_en = cnt_en && !flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
      mid_q  <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (flag_en) begin
        flag_q <= 1'b1;
        mid_q  <= mid_pick;
      end
    end
  end

  assign viol_count = cnt_q;
  assign viol_flag  = flag_q;
  assign viol_mid   = mid_q;
endmodule

// File: rtl/flash_access_guard.sv
module flash_access_guard #(
  parameter int NUM_PORTS   = 2,
  parameter int NUM_MASTERS = 8,
  parameter int ADDR_W      = 16,
  parameter int BOOT_BASE   = 'h4000,
  parameter int BOOT_SIZE   = 'h0800,
  parameter int CNT_W       = 16,
  localparam int MID_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2*NUM_MASTERS-1:0]    cfg_perm,
  input  logic                        cfg_boot_xdis,
  input  logic [NUM_PORTS-1:0]        p_req,
  input  logic [NUM_PORTS*MID_W-1:0]  p_mid,
  input  logic [NUM_PORTS-1:0]        p_write,
  input  logic [NUM_PORTS-1:0]        p_instr,
  input  logic [NUM_PORTS*ADDR_W-1:0] p_addr,
  output logic [NUM_PORTS-1:0]        p_hready,
  output logic [NUM_PORTS-1:0]        p_hresp,
  output logic [NUM_PORTS-1:0]        a_req,
  output logic [NUM_PORTS-1:0]        a_write,
  output logic [NUM_PORTS*ADDR_W-1:0] a_addr,
  output logic [CNT_W-1:0]            viol_count,
  output logic                        viol_flag,
  output logic [MID_W-1:0]            viol_mid
);
  logic                 rst_n_int;
  logic [NUM_PORTS-1:0] deny;
  logic [NUM_PORTS-1:0] err_evt;

  fg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    fg_perm_check #(
      .NUM_MASTERS (NUM_MASTERS),
      .MID_W       (MID_W),
      .ADDR_W      (ADDR_W),
      .BOOT_BASE   (BOOT_BASE),
      .BOOT_SIZE   (BOOT_SIZE)
    ) u_check (
      .cfg_perm      (cfg_perm),
      .cfg_boot_xdis (cfg_boot_xdis),
      .mid           (p_mid[g*MID_W +: MID_W]),
      .is_wr         (p_write[g]),
      .is_instr      (p_instr[g]),
      .addr          (p_addr[g*ADDR_W +: ADDR_W]),
      .deny          (deny[g])
    );

    fg_err_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .req     (p_req[g]),
      .deny    (deny[g]),
      .fwd     (a_req[g]),
      .err_evt (err_evt[g]),
      .hready  (p_hready[g]),
      .hresp   (p_hresp[g])
    );

    assign a_write[g]                  = p_write[g];
    assign a_addr[g*ADDR_W +: ADDR_W]  = p_addr[g*ADDR_W +: ADDR_W];
  end

  fg_viol_log #(
    .NUM_PORTS (NUM_PORTS),
    .MID_W     (MID_W),
    .CNT_W     (CNT_W)
  ) u_log (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .err_evt    (err_evt),
    .mid_flat   (p_mid),
    .viol_count (viol_count),
    .viol_flag  (viol_flag),
    .viol_mid   (viol_mid)
  );
endmodule

// File: rtl/flash_access_guard_chk.sv
module flash_access_guard_chk #(
  parameter int NUM_PORTS   = 2,
  parameter int NUM_MASTERS = 8,
  parameter int ADDR_W      = 16,
  parameter int BOOT_BASE   = 'h4000,
  parameter int BOOT_SIZE   = 'h0800,
  parameter int CNT_W       = 16,
  parameter int MID_W       = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [2*NUM_MASTERS-1:0]    cfg_perm,
  input logic                        cfg_boot_xdis,
  input logic [NUM_PORTS*MID_W-1:0]  p_mid,
  input logic [NUM_PORTS-1:0]        p_write,
  input logic [NUM_PORTS-1:0]        p_instr,
  input logic [NUM_PORTS*ADDR_W-1:0] p_addr,
  input logic [NUM_PORTS-1:0]        p_hready,
  input logic [NUM_PORTS-1:0]        p_hresp,
  input logic [NUM_PORTS-1:0]        a_req,
  input logic [CNT_W-1:0]            viol_count,
  input logic                        viol_flag,
  input logic [MID_W-1:0]            viol_mid
);
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BOOT_BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BOOT_BASE + BOOT_SIZE);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
    logic [ADDR_W-1:0] addr;
    logic [MID_W-1:0]  mid;
    logic              in_win;
    logic [1:0]        fld;

    always_comb begin
      addr   = p_addr[g*ADDR_W +: ADDR_W];
      mid    = p_mid[g*MID_W +: MID_W];
      in_win = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
      fld    = 2'b00;
      for (int m = 0; m < NUM_MASTERS; m++) if (mid == MID_W'(m)) fld = cfg_perm[2*m +: 2];
    end

    assert_err_second_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (p_hresp[g] && !p_hready[g]) |=> (p_hresp[g] && p_hready[g]));

    assert_no_fwd_in_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      p_hresp[g] |-> !a_req[g]);

    assert_boot_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (a_req[g] && cfg_boot_xdis && p_instr[g]) |-> !in_win);

    assert_perm_honoured_R2: assert property (@(posedge clk) disable iff (!rst_n)
      a_req[g] |-> (p_write[g] ? fld[1] : fld[0]));
  end

  assert_count_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (viol_count >= $past(viol_count)));

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag |=> (viol_flag && $stable(viol_mid)));
endmodule

bind flash_access_guard flash_access_guard_chk #(
  .NUM_PORTS   (NUM_PORTS),
  .NUM_MASTERS (NUM_MASTERS),
  .ADDR_W      (ADDR_W),
  .BOOT_BASE   (BOOT_BASE),
  .BOOT_SIZE   (BOOT_SIZE),
  .CNT_W       (CNT_W),
  .MID_W       (MID_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_perm      (cfg_perm),
  .cfg_boot_xdis (cfg_boot_xdis),
  .p_mid         (p_mid),
  .p_write       (p_write),
  .p_instr       (p_instr),
  .p_addr        (p_addr),
  .p_hready      (p_hready),
  .p_hresp       (p_hresp),
  .a_req         (a_req),
  .viol_count    (viol_count),
  .viol_flag     (viol_flag),
  .viol_mid      (viol_mid)
);

// File: tb/flash_access_guard_bench.sv
module flash_access_guard_bench;
  localparam int NP = 2;
  localparam int NM = 8;
  localparam int AW = 16;
  localparam int MW = 3;
  localparam int CW = 4;
  localparam int CMAX = 15;
  localparam logic [AW-1:0] BB = 16'h4000;
  localparam logic [AW-1:0] BS = 16'h0800;

  logic            clk;
  logic            rst_n;
  logic [2*NM-1:0] cfg_perm;
  logic            bd;
  logic [NP-1:0]   p_req, p_write, p_instr;
  logic [NP*MW-1:0] p_mid;
  logic [NP*AW-1:0] p_addr;
  logic [NP-1:0]   p_hready, p_hresp, a_req, a_write;
  logic [NP*AW-1:0] a_addr;
  logic [CW-1:0]   viol_count;
  logic            viol_flag;
  logic [MW-1:0]   viol_mid;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt;
  logic exp_flag;
  logic [MW-1:0] exp_mid;

  flash_access_guard #(
    .NUM_PORTS(NP), .NUM_MASTERS(NM), .ADDR_W(AW),
    .BOOT_BASE('h4000), .BOOT_SIZE('h0800), .CNT_W(CW)
  ) u_flash_access_guard (
    .clk(clk), .rst_n(rst_n), .cfg_perm(cfg_perm), .cfg_boot_xdis(bd),
    .p_req(p_req), .p_mid(p_mid), .p_write(p_write), .p_instr(p_instr),
    .p_addr(p_addr), .p_hready(p_hready), .p_hresp(p_hresp),
    .a_req(a_req), .a_write(a_write), .a_addr(a_addr),
    .viol_count(viol_count), .viol_flag(viol_flag), .viol_mid(viol_mid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  task automatic note_violation(input logic [MW-1:0] mid);
    if (exp_cnt < CMAX) exp_cnt++;
    if (!exp_flag) begin
      exp_flag = 1'b1;
      exp_mid  = mid;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    p_req = '0; p_write = '0; p_instr = '0; p_mid = '0; p_addr = '0;
    repeat (2) @(negedge clk);
    check(p_hready == 2'b11 && p_hresp == 2'b00, "R1 ready/resp in reset", {p_hready, p_hresp}, 'hC);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_cnt = 0; exp_flag = 1'b0; exp_mid = '0;
    check(p_hready == 2'b11 && p_hresp == 2'b00, "R1 ready/resp", {p_hready, p_hresp}, 'hC);
    check(a_req == 2'b00, "R1 a_req", a_req, 0);
    check(viol_count == 0 && !viol_flag, "R1 count/flag", {viol_count, viol_flag}, 0);
  endtask

  task automatic tx(input int p, input logic [MW-1:0] mid, input bit wr, input bit ins,
                    input logic [AW-1:0] addr);
    logic [1:0] f;
    bit in_win, v;
    string tag;
    int q;
    f      = cfg_perm[2*mid +: 2];
    in_win = (addr >= BB) && (addr < BB + BS);
    v      = (wr ? !f[1] : !f[0]) || (bd && ins && in_win);
    tag    = (bd && ins && in_win) ? "R4" : (in_win ? "R5" : "R2");
    q      = 1 - p;
    @(negedge clk);
    p_req[p] = 1'b1; p_write[p] = wr; p_instr[p] = ins;
    p_mid[p*MW +: MW] = mid; p_addr[p*AW +: AW] = addr;
    #1;
    check(p_hresp[p] == 1'b0 && p_hready[p] == 1'b1, "R3 idle before request", {p_hready[p], p_hresp[p]}, 2);
    check(a_req[p] == !v, tag, a_req[p], !v);
    if (!v) check(a_addr[p*AW +: AW] == addr && a_write[p] == wr, "R2 forwarded fields",
                  a_addr[p*AW +: AW], addr);
    @(negedge clk);
    p_req[p] = 1'b0;
    if (v) note_violation(mid);
    check(p_hready[p] == !v && p_hresp[p] == v, "R3 first beat", {p_hready[p], p_hresp[p]}, {!v, v});
    check(p_hready[q] == 1'b1 && p_hresp[q] == 1'b0, "R6 other port quiet", {p_hready[q], p_hresp[q]}, 2);
    check(int'(viol_count) == exp_cnt, "R8 count", viol_count, exp_cnt);
    if (v) begin
      @(negedge clk);
      check(p_hready[p] == 1'b1 && p_hresp[p] == 1'b1, "R3 second beat", {p_hready[p], p_hresp[p]}, 3);
    end
  endtask

  initial begin
    logic [AW-1:0] addrs [4];
    addrs[0] = BB - 16'd1; addrs[1] = BB; addrs[2] = BB + BS - 16'd1; addrs[3] = BB + BS;
    bd = 1'b0;
    cfg_perm = '0;

    for (int k = 0; k < 4; k++) begin
      for (int m = 0; m < NM; m++) cfg_perm[2*m +: 2] = 2'((m + k) % 4);
      bd = 1'b0;
      do_reset();
      for (int b = 0; b < 2; b++) begin
        bd = b[0];
        for (int p = 0; p < NP; p++)
          for (int m = 0; m < NM; m++)
            for (int w = 0; w < 2; w++)
              for (int i = 0; i < 2; i++)
                for (int a = 0; a < 4; a++)
                  tx(p, 3'(m), w[0], i[0], addrs[a]);
      end
      @(negedge clk);
      check(viol_flag == exp_flag && viol_mid == exp_mid, "R9 sticky after sweep", viol_mid, exp_mid);
      check(int'(viol_count) == exp_cnt, "R8 saturated count", viol_count, exp_cnt);
    end

    // R6 / R9: both ports refused in the same cycle
    cfg_perm = '0; bd = 1'b0;
    do_reset();
    @(negedge clk);
    p_req = 2'b11; p_write = 2'b01; p_instr = 2'b00;
    p_mid[0 +: MW] = 3'd3; p_mid[MW +: MW] = 3'd5;
    p_addr = {16'h1000, 16'h2000};
    #1;
    check(a_req == 2'b00, "R6 both withheld", a_req, 0);
    @(negedge clk);
    p_req = 2'b00;
    check(p_hready == 2'b00 && p_hresp == 2'b11, "R6 both first beat", {p_hready, p_hresp}, 3);
    check(viol_count == 4'd2, "R8 two in one cycle", viol_count, 2);
    check(viol_flag && viol_mid == 3'd3, "R9 port0 priority", viol_mid, 3);
    @(negedge clk);
    check(p_hready == 2'b11 && p_hresp == 2'b11, "R6 both second beat", {p_hready, p_hresp}, 'hF);

    // R7: request held through the error beats
    cfg_perm = 16'h000C;  // master 1 read+write, others none
    @(negedge clk);
    p_req[0] = 1'b1; p_write[0] = 1'b0; p_mid[0 +: MW] = 3'd0;
    @(negedge clk);
    p_mid[0 +: MW] = 3'd1;
    #1;
    check(a_req[0] == 1'b0, "R7 drop in first beat", a_req[0], 0);
    @(negedge clk);
    #1;
    check(a_req[0] == 1'b0, "R7 drop in second beat", a_req[0], 0);
    @(negedge clk);
    #1;
    check(a_req[0] == 1'b1, "R7 judged on return to idle", a_req[0], 1);
    @(negedge clk);
    p_req = '0;
    check(viol_count == 4'd3 && p_hresp[0] == 1'b0, "R7 not counted", viol_count, 3);
    check(viol_flag && viol_mid == 3'd3, "R9 held", viol_mid, 3);

    finish_run();
  end
endmodule